// File: doc/BRIEF.md
# Exception State Registers

This block keeps the trap-related control state of a small RISC core: a general exception return PC, a separate error-trap return PC, a status word and a cause word. The pipeline reports a taken exception with a single strobe. The strobe carries a class (general or error), a 5-bit code, the faulting PC, a delay-slot flag and the PC of the branch that precedes the slot. The block sets the matching level bit and captures the return address. It does not capture a new general return address while the core is already handling a general exception.

A return strobe leaves the innermost level. While the error level is set, `ret_addr_o` shows the error return PC; otherwise it shows the general one. The block also derives a global interrupt-enable qualifier, the current priority level and the operating mode from the status bits and a debug-mode input. Software reads and writes the four registers through a simple select/write port.

Top module: `exc_ctrl`

## Requirements
- R1: A taken general exception (`exc_i`=1, `exc_err_i`=0) sets the exception-level bit (status bit 1). A taken error exception (`exc_err_i`=1) sets the error-level bit (status bit 2) instead. Both bits are visible after the next clock edge.
- R2: On a general exception taken at exception level 0, the general return PC is loaded with `exc_pc_i`. If `exc_bd_i`=1, it is loaded with `exc_br_pc_i` instead. The branch-delay bit (cause bit 31) takes the value of `exc_bd_i`.
- R3: When a general exception is taken while the exception-level bit is already 1, the general return PC and the branch-delay bit keep their values.
- R4: An error exception loads the error return PC, using the same delay-slot selection as R2. It leaves the general return PC and the branch-delay bit unchanged.
- R5: `ret_addr_o` equals the error return PC while the error-level bit is 1, and the general return PC otherwise.
- R6: A return strobe clears the error-level bit if it is set; otherwise it clears the exception-level bit.
- R7: `int_en_o` is 1 only when IE (status bit 0) is 1, the exception-level bit is 0, the error-level bit is 0 and `dbg_i` is 0.
- R8: `mode_o` is 2'b10 (debug) whenever `dbg_i`=1. Otherwise it is 2'b01 (user) when UM (status bit 4) is 1 and both level bits are 0, and 2'b00 (kernel) for every other combination.
- R9: After reset the status word reads 32'h0040_0000: only the boot-vector bit, status bit 22, is set, and `bev_o` is 1. The cause word and both return PCs read 0.
- R10: Every taken exception, of either class and at any level, writes `exc_code_i` into cause bits 6:2.
- R11: With `sw_we_i`=1, `sw_sel_i` selects the target: 0 status, 1 cause, 2 general return PC, 3 error return PC. The write takes effect at the next clock edge. Writable fields are status bits 0, 1, 2, 4, 12:10 and 22, and cause bits 6:2. Every other bit reads 0, and the branch-delay bit is not writable. PCs are zero-extended on read. `sw_rdata_o` reflects the selected register combinationally.
- R12: In a cycle with `exc_i`=1, a return strobe and any software write are ignored. In a cycle with a return strobe and no exception, a software write is ignored.
- R13: `ipl_o` equals status bits 12:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_i | input | 1 | Exception taken this cycle |
| exc_err_i | input | 1 | Exception class: 1 error, 0 general |
| exc_code_i | input | 5 | Exception code |
| exc_pc_i | input | PC_W | Faulting instruction PC |
| exc_bd_i | input | 1 | Faulting instruction sits in a delay slot |
| exc_br_pc_i | input | PC_W | PC of the preceding branch or jump |
| eret_i | input | 1 | Return-from-exception strobe |
| dbg_i | input | 1 | Core is in debug mode |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 2 | Register select |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Selected register contents |
| ret_addr_o | output | PC_W | Resume address for a return |
| int_en_o | output | 1 | Global interrupt enable qualifier |
| ipl_o | output | 3 | Current interrupt priority level |
| mode_o | output | 2 | Operating mode |
| bev_o | output | 1 | Boot vector select |

## Verification
The bench builds the block with `PC_W`=16. This keeps the return PCs narrow enough that the zero-extension of the upper read bits and the truncation of software-written PCs are both exposed. With a 5-bit code and five qualifying status inputs (IE, both level bits, UM, debug), the bench sweeps all 32 combinations for the interrupt-enable and mode outputs and all 32 codes through the cause field. It also walks through nested exceptions, error traps on top of general traps, and same-cycle collisions between capture, return and software writes.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int DATA_W    = 32;
  localparam int IPL_W     = 3;
  localparam int CODE_W    = 5;
  localparam int ST_IE     = 0;
  localparam int ST_EXL    = 1;
  localparam int ST_ERL    = 2;
  localparam int ST_UM     = 4;
  localparam int ST_IPL_LO = 10;
  localparam int ST_BEV    = 22;
  localparam int CA_CODE_LO = 2;
  localparam int CA_BD     = 31;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_EEPC   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_USER   = 2'b01,
    MODE_DEBUG  = 2'b10
  } cpu_mode_e;

  typedef struct packed {
    logic             bev;
    logic [IPL_W-1:0] ipl;
    logic             um;
    logic             erl;
    logic             exl;
    logic             ie;
  } status_t;
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic              exc_err_i,
  input  logic              eret_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output status_t           st_o
);
  status_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '0;
      st_q.bev <= 1'b1;
    end else if (exc_i) begin
      if (exc_err_i) st_q.erl <= 1'b1;
      else           st_q.exl <= 1'b1;
    end else if (eret_i) begin
      // leave the innermost level only
      if (st_q.erl) st_q.erl <= 1'b0;
      else          st_q.exl <= 1'b0;
    end else if (wr_i) begin
      st_q.ie  <= wdata_i[ST_IE];
      st_q.exl <= wdata_i[ST_EXL];
      st_q.erl <= wdata_i[ST_ERL];
      st_q.um  <= wdata_i[ST_UM];
      st_q.ipl <= wdata_i[ST_IPL_LO +: IPL_W];
      st_q.bev <= wdata_i[ST_BEV];
    end
  end

  assign st_o = st_q;

  p_exl_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !exc_err_i |=> st_q.exl);
  p_erl_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && exc_err_i |=> st_q.erl);
  p_eret_erl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !exc_i && st_q.erl |=> !st_q.erl && $stable(st_q.exl));
  p_eret_exl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !exc_i && !st_q.erl |=> !st_q.exl);
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic              exc_err_i,
  input  logic              exl_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              bd_o
);
  logic [CODE_W-1:0] code_q;
  logic              bd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      bd_q   <= 1'b0;
    end else if (exc_i) begin
      code_q <= code_i;
      if (!exc_err_i && !exl_i) bd_q <= bd_i;
    end else if (wr_i) begin
      code_q <= wdata_i[CA_CODE_LO +: CODE_W];
    end
  end

  assign code_o = code_q;
  assign bd_o   = bd_q;

  p_bd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && (exc_err_i || exl_i) |=> $stable(bd_q));
  p_code_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> code_q == $past(code_i));
endmodule

// File: rtl/exc_pc_bank.sv
module exc_pc_bank
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic              exc_err_i,
  input  logic              exl_i,
  input  logic [PC_W-1:0]   exc_pc_i,
  input  logic              exc_bd_i,
  input  logic [PC_W-1:0]   exc_br_pc_i,
  input  logic              wr_epc_i,
  input  logic              wr_eepc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PC_W-1:0]   epc_o,
  output logic [PC_W-1:0]   eepc_o
);
  localparam int NREG = 2;

  logic [PC_W-1:0] cap_pc;
  logic [PC_W-1:0] pc_q [NREG];

  assign cap_pc = exc_bd_i ? exc_br_pc_i : exc_pc_i;

  for (genvar g = 0; g < NREG; g++) begin : g_pc
    logic cap, wr;
    // slot 0: general return PC, slot 1: error return PC
    assign cap = (g == 0) ? (exc_i && !exc_err_i && !exl_i) : (exc_i && exc_err_i);
    assign wr  = (g == 0) ? wr_epc_i : wr_eepc_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             pc_q[g] <= '0;
      else if (cap)            pc_q[g] <= cap_pc;
      else if (wr && !exc_i)   pc_q[g] <= wdata_i[PC_W-1:0];
    end
  end

  assign epc_o  = pc_q[0];
  assign eepc_o = pc_q[1];

  p_epc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !exc_err_i && exl_i |=> $stable(epc_o));
  p_err_keeps_epc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && exc_err_i |=> $stable(epc_o));
endmodule

// File: rtl/exc_mode_dec.sv
module exc_mode_dec
  import exc_pkg::*;
(
  input  status_t    st_i,
  input  logic       dbg_i,
  output logic       int_en_o,
  output logic [1:0] mode_o
);
  logic at_level;

  assign at_level = st_i.exl | st_i.erl;
  assign int_en_o = st_i.ie & ~at_level & ~dbg_i;

  always_comb begin
    if (dbg_i)                     mode_o = MODE_DEBUG;
    else if (st_i.um && !at_level) mode_o = MODE_USER;
    else                           mode_o = MODE_KERNEL;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic              exc_err_i,
  input  logic [4:0]        exc_code_i,
  input  logic [PC_W-1:0]   exc_pc_i,
  input  logic              exc_bd_i,
  input  logic [PC_W-1:0]   exc_br_pc_i,
  input  logic              eret_i,
  input  logic              dbg_i,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_sel_i,
  input  logic [31:0]       sw_wdata_i,
  output logic [31:0]       sw_rdata_o,
  output logic [PC_W-1:0]   ret_addr_o,
  output logic              int_en_o,
  output logic [2:0]        ipl_o,
  output logic [1:0]        mode_o,
  output logic              bev_o
);
  status_t           st;
  logic [CODE_W-1:0] code;
  logic              bd;
  logic [PC_W-1:0]   epc, eepc;
  logic              wr_ok;
  logic              wr_st, wr_ca, wr_epc, wr_eepc;

  // exception beats return, return beats software
  assign wr_ok   = sw_we_i && !exc_i && !eret_i;
  assign wr_st   = wr_ok && (sw_sel_i == SEL_STATUS);
  assign wr_ca   = wr_ok && (sw_sel_i == SEL_CAUSE);
  assign wr_epc  = wr_ok && (sw_sel_i == SEL_EPC);
  assign wr_eepc = wr_ok && (sw_sel_i == SEL_EEPC);

  exc_status_reg u_status (
    .clk_i, .rst_ni, .exc_i, .exc_err_i, .eret_i,
    .wr_i(wr_st), .wdata_i(sw_wdata_i), .st_o(st)
  );

  exc_cause_reg u_cause (
    .clk_i, .rst_ni, .exc_i, .exc_err_i,
    .exl_i(st.exl), .code_i(exc_code_i), .bd_i(exc_bd_i),
    .wr_i(wr_ca), .wdata_i(sw_wdata_i), .code_o(code), .bd_o(bd)
  );

  exc_pc_bank #(.PC_W(PC_W)) u_pcs (
    .clk_i, .rst_ni, .exc_i, .exc_err_i, .exl_i(st.exl),
    .exc_pc_i, .exc_bd_i, .exc_br_pc_i,
    .wr_epc_i(wr_epc), .wr_eepc_i(wr_eepc), .wdata_i(sw_wdata_i),
    .epc_o(epc), .eepc_o(eepc)
  );

  exc_mode_dec u_mode (
    .st_i(st), .dbg_i, .int_en_o, .mode_o
  );

  always_comb begin
    sw_rdata_o = '0;
    unique case (sw_sel_i)
      SEL_STATUS: begin
        sw_rdata_o[ST_IE]                 = st.ie;
        sw_rdata_o[ST_EXL]                = st.exl;
        sw_rdata_o[ST_ERL]                = st.erl;
        sw_rdata_o[ST_UM]                 = st.um;
        sw_rdata_o[ST_IPL_LO +: IPL_W]    = st.ipl;
        sw_rdata_o[ST_BEV]                = st.bev;
      end
      SEL_CAUSE: begin
        sw_rdata_o[CA_CODE_LO +: CODE_W]  = code;
        sw_rdata_o[CA_BD]                 = bd;
      end
      SEL_EPC:  sw_rdata_o[PC_W-1:0] = epc;
      default:  sw_rdata_o[PC_W-1:0] = eepc;
    endcase
  end

  assign ret_addr_o = st.erl ? eepc : epc;
  assign ipl_o      = st.ipl;
  assign bev_o      = st.bev;

  p_int_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_o |-> !dbg_i && !st.exl && !st.erl && st.ie);
  p_mode_dbg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |-> mode_o == MODE_DEBUG);
  p_wr_blocked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !exc_i && sw_we_i && sw_sel_i == SEL_EPC |=> $stable(epc));
  p_exc_beats_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !exc_err_i && sw_we_i && sw_sel_i == SEL_STATUS |=> st.exl);
endmodule

// File: tb/sim_exc_ctrl.sv
`timescale 1ns/1ps
module sim_exc_ctrl;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc = 0, exc_err = 0, exc_bd = 0, eret = 0, dbg = 0, sw_we = 0;
  logic [4:0] exc_code = '0;
  logic [PW-1:0] exc_pc = '0, exc_br = '0;
  logic [1:0] sw_sel = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic [PW-1:0] ret_addr;
  logic int_en, bev;
  logic [2:0] ipl;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  exc_ctrl #(.PC_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .exc_i(exc), .exc_err_i(exc_err),
    .exc_code_i(exc_code), .exc_pc_i(exc_pc), .exc_bd_i(exc_bd),
    .exc_br_pc_i(exc_br), .eret_i(eret), .dbg_i(dbg), .sw_we_i(sw_we),
    .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata),
    .ret_addr_o(ret_addr), .int_en_o(int_en), .ipl_o(ipl), .mode_o(mode),
    .bev_o(bev)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    sw_sel = s;
    #0.2;
    v = sw_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    sw_we = 1; sw_sel = s; sw_wdata = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic take(input logic err, input logic [4:0] c, input logic [PW-1:0] pc,
                      input logic bd, input logic [PW-1:0] br);
    exc = 1; exc_err = err; exc_code = c; exc_pc = pc; exc_bd = bd; exc_br = br;
    @(negedge clk);
    exc = 0; exc_err = 0; exc_bd = 0;
  endtask

  task automatic do_eret();
    eret = 1;
    @(negedge clk);
    eret = 0;
  endtask

  function automatic logic [31:0] st_word(logic ie, logic exl, logic erl, logic um,
                                          logic bv, logic [2:0] pl);
    return {9'd0, bv, 9'd0, pl, 5'd0, um, 1'b0, erl, exl, ie};
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 reset values
    rd(0, v); check("R9 status", v, 32'h0040_0000);
    rd(1, v); check("R9 cause", v, 0);
    rd(2, v); check("R9 epc", v, 0);
    rd(3, v); check("R9 eepc", v, 0);
    check("R9 bev_o", {31'd0, bev}, 1);
    check("R8 reset mode kernel", {30'd0, mode}, 0);
    check("R7 reset int_en", {31'd0, int_en}, 0);

    // R7 R8 R11 R13 sweep of status bits and debug
    for (int i = 0; i < 32; i++) begin
      logic ie_b, exl_b, erl_b, um_b, dbg_b;
      logic [2:0] pl;
      logic [1:0] em;
      ie_b = i[0]; exl_b = i[1]; erl_b = i[2]; um_b = i[3]; dbg_b = i[4];
      pl = 3'(i % 8);
      dbg = dbg_b;
      wr(0, st_word(ie_b, exl_b, erl_b, um_b, 1'b1, pl) | 32'h8000_0108);
      rd(0, v); check("R11 status readback", v, st_word(ie_b, exl_b, erl_b, um_b, 1'b1, pl));
      check("R13 ipl", {29'd0, ipl}, {29'd0, pl});
      check("R7 int_en", {31'd0, int_en},
            {31'd0, ie_b && !exl_b && !erl_b && !dbg_b});
      em = dbg_b ? 2'b10 : (um_b && !exl_b && !erl_b) ? 2'b01 : 2'b00;
      check("R8 mode", {30'd0, mode}, {30'd0, em});
    end
    dbg = 0;
    wr(0, 32'h0040_0011);

    // R1 R2 R5 R10 general exception
    take(0, 5'd3, 16'h1234, 0, 16'h0);
    rd(0, v); check("R1 exl set", v, 32'h0040_0013);
    rd(2, v); check("R2 epc", v, 32'h1234);
    rd(1, v); check("R10 cause code", v, 32'h0000_000C);
    check("R5 ret epc", {16'd0, ret_addr}, 32'h1234);
    check("R7 at level", {31'd0, int_en}, 0);
    check("R8 kernel at level", {30'd0, mode}, 0);

    // R3 nested general exception
    take(0, 5'd7, 16'h5555, 1, 16'h5551);
    rd(2, v); check("R3 epc held", v, 32'h1234);
    rd(1, v); check("R3 bd held / R10 code", v, 32'h0000_001C);

    // R6 return clears exl
    do_eret();
    rd(0, v); check("R6 exl cleared", v, 32'h0040_0011);
    check("R8 user again", {30'd0, mode}, 1);
    check("R7 enabled again", {31'd0, int_en}, 1);

    // R2 delay slot
    take(0, 5'd9, 16'h2004, 1, 16'h2000);
    rd(2, v); check("R2 epc branch", v, 32'h2000);
    rd(1, v); check("R2 bd set", v, 32'h8000_0024);

    // R4 error exception on top
    take(1, 5'h1e, 16'h0abc, 0, 16'h0);
    rd(0, v); check("R1 erl set", v, 32'h0040_0017);
    rd(3, v); check("R4 eepc", v, 32'h0abc);
    rd(2, v); check("R4 epc kept", v, 32'h2000);
    rd(1, v); check("R4 bd kept", v, 32'h8000_0078);
    check("R5 ret eepc", {16'd0, ret_addr}, 32'h0abc);

    do_eret();
    rd(0, v); check("R6 erl cleared first", v, 32'h0040_0013);
    check("R5 ret back to epc", {16'd0, ret_addr}, 32'h2000);
    do_eret();
    rd(0, v); check("R6 exl cleared second", v, 32'h0040_0011);

    // R12 exception beats software write
    sw_we = 1; sw_sel = 0; sw_wdata = 0;
    take(0, 5'd2, 16'h0100, 0, 16'h0);
    sw_we = 0;
    rd(0, v); check("R12 exc over write", v, 32'h0040_0013);
    do_eret();
    // R12 exception beats return
    eret = 1;
    take(0, 5'd4, 16'h0200, 0, 16'h0);
    eret = 0;
    rd(0, v); check("R12 exc over eret", v, 32'h0040_0013);
    rd(2, v); check("R12 epc from exc", v, 32'h0200);
    // R12 return beats software write
    sw_we = 1; sw_sel = 2; sw_wdata = 32'h0000_BEEF;
    do_eret();
    sw_we = 0;
    rd(2, v); check("R12 eret over write", v, 32'h0200);
    rd(0, v); check("R12 eret applied", v, 32'h0040_0011);

    // R11 write timing and fields
    sw_we = 1; sw_sel = 2; sw_wdata = 32'h0000_7777;
    #0.2; check("R11 not before edge", sw_rdata, 32'h0200);
    @(negedge clk); sw_we = 0;
    rd(2, v); check("R11 epc written", v, 32'h7777);
    wr(3, 32'h0000_0f0f);
    rd(3, v); check("R11 eepc written", v, 32'h0f0f);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); check("R11 cause code only", v, 32'h0000_007C);
    wr(2, 32'hFFFF_ABCD);
    rd(2, v); check("R11 pc zero-extended", v, 32'h0000_ABCD);

    // R10 code sweep
    for (int c = 0; c < 32; c++) begin
      take(c[0], 5'(c), 16'h0300, 0, 16'h0);
      rd(1, v); check("R10 code sweep", (v >> 2) & 32'h1F, 32'(c));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule